// File: doc/BRIEF.md
# Two-Client Preemptive Quantum Arbiter

This block decides which of two engines, a transmit engine and a receive engine, may drive the single bus that both share toward the MAC. Each engine raises a request, is told through its own grant that it owns the bus, and can hand the bus back early by pulsing done. At most one grant is ever high.

Ownership is time-sliced. On every new grant a down-counter is loaded with that client's own quantum, counted in clock cycles, and each client has a separate quantum length. If the quantum runs out while the other client is waiting, the owner is preempted. The bus then stays idle for one cycle, and after that the waiting client takes it. If nobody is waiting, the owner keeps the bus and its quantum is refilled. When both clients ask at once with no owner, the client that did not receive the previous grant wins. After reset that is the receive client.

Top module: `qarb_bus_arbiter`

## Requirements
- R1: `gnt_tx` and `gnt_rx` are never high together. Both stay low while no request is pending.
- R2: With the bus idle and only one client requesting, that client's grant is high from the next clock edge.
- R3: The first time both clients request together after reset with no owner, `gnt_rx` is granted.
- R4: Later simultaneous requests with no owner go to the client that was not granted last.
- R5: An owner whose rival is requesting holds its grant for exactly its quantum: `TX_QUANTUM` cycles for transmit and `RX_QUANTUM` cycles for receive. It loses the grant after that.
- R6: An owner whose quantum expires while the rival is not requesting keeps its grant without a gap.
- R7: An owner that asserts its done input loses its grant at the next clock edge (early finish).
- R8: An owner that drops its request loses its grant at the next clock edge.
- R9: Whenever the bus changes hands, there is exactly one cycle in which both grants are low.
- R10: A done input from the client that does not own the bus has no effect on either grant.
- R11: A synchronous active-high reset clears both grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_tx | input | 1 | Transmit engine requests the bus |
| done_tx | input | 1 | Transmit engine releases the bus early |
| gnt_tx | output | 1 | Transmit engine owns the bus |
| req_rx | input | 1 | Receive engine requests the bus |
| done_rx | input | 1 | Receive engine releases the bus early |
| gnt_rx | output | 1 | Receive engine owns the bus |

## Verification
The bench builds the arbiter with a transmit quantum of 3 cycles and a receive quantum of 5 cycles. Because these quanta are short and unequal, a single run contains many full preemption rounds. The exact length of each ownership period can therefore be measured, and it is clear which quantum is applied to which client. The short quanta also bring expiry into reach at the same moment as a done pulse, a dropped request or a new request from the rival. This happens both in the directed cases and in a long stretch of pseudo-random stimulus.

// File: rtl/qarb_pkg.sv
`timescale 1ns/1ps
package qarb_pkg;
   localparam int unsigned NCLI   = 2;
   localparam int unsigned CLI_TX = 0;
   localparam int unsigned CLI_RX = 1;

   typedef enum logic [1:0] {
      OWN_IDLE = 2'd0,
      OWN_TX   = 2'd1,
      OWN_RX   = 2'd2
   } own_e;
endpackage

// File: rtl/qarb_client.sv
`timescale 1ns/1ps
// Per-client qualification: whether the current grant may be kept.
module qarb_client (
   input  logic req,
   input  logic done,
   input  logic gnt,
   output logic hold
);
   // A grant survives only while the client still asks and has not finished.
   assign hold = gnt & req & ~done;
endmodule

// File: rtl/qarb_quantum.sv
`timescale 1ns/1ps
// Slice counter: loaded with the new owner's quantum, counts down while held.
module qarb_quantum #(
   parameter int unsigned TX_QUANTUM = 16,
   parameter int unsigned RX_QUANTUM = 24,
   parameter int unsigned CNT_W      = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic load_rx,
   input  logic dec,
   input  logic clear,
   output logic q_last
);
   localparam int unsigned QMAX = (TX_QUANTUM > RX_QUANTUM) ? TX_QUANTUM : RX_QUANTUM;
   localparam logic [CNT_W-1:0] TXV = CNT_W'(TX_QUANTUM);
   localparam logic [CNT_W-1:0] RXV = CNT_W'(RX_QUANTUM);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   generate
      if (TX_QUANTUM == RX_QUANTUM) begin : g_same_q
         assign load_val = TXV;
         logic unused_sel;
         assign unused_sel = load_rx;
      end else begin : g_split_q
         assign load_val = load_rx ? RXV : TXV;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)        cnt_q <= '0;
      else if (load)  cnt_q <= load_val;
      else if (dec)   cnt_q <= cnt_q - 1'b1;
      else if (clear) cnt_q <= '0;
   end

   assign q_last = (cnt_q == CNT_W'(1));

   // R5: the slice never exceeds the largest quantum
   a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_W'(QMAX));
   // R5: a decrement is never asked of an empty counter
   a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
      dec |-> (cnt_q != '0));
endmodule

// File: rtl/qarb_decide.sv
`timescale 1ns/1ps
// Next-owner decision for the two-client time-sliced policy.
module qarb_decide
   import qarb_pkg::*;
(
   input  own_e            cur,
   input  logic [NCLI-1:0] req,
   input  logic [NCLI-1:0] hold,
   input  logic            tie_rx,
   input  logic            q_last,
   output own_e            nxt,
   output logic            load,
   output logic            load_rx,
   output logic            dec
);
   always_comb begin
      nxt     = cur;
      load    = 1'b0;
      load_rx = 1'b0;
      dec     = 1'b0;
      unique case (cur)
         OWN_IDLE: begin
            if (req[CLI_TX] && req[CLI_RX]) begin
               nxt     = tie_rx ? OWN_RX : OWN_TX;
               load    = 1'b1;
               load_rx = tie_rx;
            end else if (req[CLI_RX]) begin
               nxt     = OWN_RX;
               load    = 1'b1;
               load_rx = 1'b1;
            end else if (req[CLI_TX]) begin
               nxt  = OWN_TX;
               load = 1'b1;
            end
         end
         OWN_TX: begin
            if (!hold[CLI_TX])   nxt = OWN_IDLE;
            else if (q_last) begin
               if (req[CLI_RX])  nxt = OWN_IDLE;
               else              load = 1'b1;
            end else             dec = 1'b1;
         end
         OWN_RX: begin
            if (!hold[CLI_RX])   nxt = OWN_IDLE;
            else if (q_last) begin
               if (req[CLI_TX])  nxt = OWN_IDLE;
               else begin
                  load    = 1'b1;
                  load_rx = 1'b1;
               end
            end else             dec = 1'b1;
         end
         default: nxt = OWN_IDLE;
      endcase
   end
endmodule

// File: rtl/qarb_bus_arbiter.sv
`timescale 1ns/1ps
// Two-client preemptive time-sliced bus arbiter (top).
module qarb_bus_arbiter
   import qarb_pkg::*;
#(
   parameter int unsigned TX_QUANTUM = 16,
   parameter int unsigned RX_QUANTUM = 24
) (
   input  logic clk,
   input  logic rst,
   input  logic req_tx,
   input  logic done_tx,
   output logic gnt_tx,
   input  logic req_rx,
   input  logic done_rx,
   output logic gnt_rx
);
   localparam int unsigned QMAX  = (TX_QUANTUM > RX_QUANTUM) ? TX_QUANTUM : RX_QUANTUM;
   localparam int unsigned CNT_W = $clog2(QMAX + 1);

   initial begin : p_param_chk
      assert (TX_QUANTUM >= 1) else $error("TX_QUANTUM must be at least 1");
      assert (RX_QUANTUM >= 1) else $error("RX_QUANTUM must be at least 1");
   end

   own_e            own_q, own_d;
   logic            tie_rx_q;
   logic [NCLI-1:0] req_v, done_v, gnt_v, hold_v;
   logic            load, load_rx, dec, q_last;

   assign req_v[CLI_TX]  = req_tx;
   assign req_v[CLI_RX]  = req_rx;
   assign done_v[CLI_TX] = done_tx;
   assign done_v[CLI_RX] = done_rx;
   assign gnt_v[CLI_TX]  = (own_q == OWN_TX);
   assign gnt_v[CLI_RX]  = (own_q == OWN_RX);

   generate
      for (genvar c = 0; c < NCLI; c++) begin : g_cli
         qarb_client u_cli (
            .req  (req_v[c]),
            .done (done_v[c]),
            .gnt  (gnt_v[c]),
            .hold (hold_v[c])
         );
      end
   endgenerate

   qarb_decide u_decide (
      .cur     (own_q),
      .req     (req_v),
      .hold    (hold_v),
      .tie_rx  (tie_rx_q),
      .q_last  (q_last),
      .nxt     (own_d),
      .load    (load),
      .load_rx (load_rx),
      .dec     (dec)
   );

   qarb_quantum #(
      .TX_QUANTUM (TX_QUANTUM),
      .RX_QUANTUM (RX_QUANTUM),
      .CNT_W      (CNT_W)
   ) u_quantum (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .load_rx (load_rx),
      .dec     (dec),
      .clear   (own_d == OWN_IDLE),
      .q_last  (q_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         own_q    <= OWN_IDLE;
         tie_rx_q <= 1'b1;
      end else begin
         own_q <= own_d;
         if (own_q == OWN_IDLE && load) tie_rx_q <= ~load_rx;
      end
   end

   assign gnt_tx = gnt_v[CLI_TX];
   assign gnt_rx = gnt_v[CLI_RX];

   // R1: never two owners
   a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0({gnt_tx, gnt_rx}));
   // R1: no request, no grant
   a_r1_no_req_tx: assert property (@(posedge clk) disable iff (rst)
      (!gnt_tx && !req_tx) |=> !gnt_tx);
   a_r1_no_req_rx: assert property (@(posedge clk) disable iff (rst)
      (!gnt_rx && !req_rx) |=> !gnt_rx);
   // R2: lone requester on idle bus
   a_r2_lone_tx: assert property (@(posedge clk) disable iff (rst)
      (!gnt_tx && !gnt_rx && req_tx && !req_rx) |=> gnt_tx);
   a_r2_lone_rx: assert property (@(posedge clk) disable iff (rst)
      (!gnt_tx && !gnt_rx && req_rx && !req_tx) |=> gnt_rx);
   // R5: expiry with a waiting rival preempts the owner
   a_r5_preempt_tx: assert property (@(posedge clk) disable iff (rst)
      (gnt_tx && q_last && req_rx) |=> !gnt_tx);
   a_r5_preempt_rx: assert property (@(posedge clk) disable iff (rst)
      (gnt_rx && q_last && req_tx) |=> !gnt_rx);
   // R6: nobody waiting, owner keeps the bus
   a_r6_keep_tx: assert property (@(posedge clk) disable iff (rst)
      (gnt_tx && req_tx && !done_tx && !req_rx) |=> gnt_tx);
   a_r6_keep_rx: assert property (@(posedge clk) disable iff (rst)
      (gnt_rx && req_rx && !done_rx && !req_tx) |=> gnt_rx);
   // R7: early finish
   a_r7_done_tx: assert property (@(posedge clk) disable iff (rst)
      (gnt_tx && done_tx) |=> !gnt_tx);
   a_r7_done_rx: assert property (@(posedge clk) disable iff (rst)
      (gnt_rx && done_rx) |=> !gnt_rx);
   // R8: withdrawn request releases
   a_r8_drop_tx: assert property (@(posedge clk) disable iff (rst)
      (gnt_tx && !req_tx) |=> !gnt_tx);
   a_r8_drop_rx: assert property (@(posedge clk) disable iff (rst)
      (gnt_rx && !req_rx) |=> !gnt_rx);
   // R9: idle cycle on every hand-over
   a_r9_gap_tx: assert property (@(posedge clk) disable iff (rst)
      gnt_tx |=> !gnt_rx);
   a_r9_gap_rx: assert property (@(posedge clk) disable iff (rst)
      gnt_rx |=> !gnt_tx);
endmodule

// File: tb/qarb_bus_arbiter_tb.sv
`timescale 1ns/1ps
module qarb_bus_arbiter_tb;
   localparam int TQ = 3;
   localparam int RQ = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic req_tx = 1'b0, done_tx = 1'b0, req_rx = 1'b0, done_rx = 1'b0;
   logic gnt_tx, gnt_rx;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   string tag = "R11";

   // reference model state: 0 idle, 1 transmit, 2 receive
   int m_own = 0;
   int m_left = 0;
   int m_last = 1;   // last client granted; tie goes to the other one

   always #5 clk = ~clk;

   qarb_bus_arbiter #(.TX_QUANTUM(TQ), .RX_QUANTUM(RQ)) u_dut (
      .clk(clk), .rst(rst),
      .req_tx(req_tx), .done_tx(done_tx), .gnt_tx(gnt_tx),
      .req_rx(req_rx), .done_rx(done_rx), .gnt_rx(gnt_rx)
   );

   always @(posedge clk) begin
      if (rst) begin
         m_own = 0; m_left = 0; m_last = 1;
      end else if (m_own == 0) begin
         if (req_tx && req_rx)  m_own = (m_last == 1) ? 2 : 1;
         else if (req_rx)       m_own = 2;
         else if (req_tx)       m_own = 1;
         if (m_own != 0) begin
            m_last = m_own;
            m_left = (m_own == 1) ? TQ : RQ;
         end
      end else begin
         bit mine_req, mine_done, other_req;
         mine_req  = (m_own == 1) ? req_tx  : req_rx;
         mine_done = (m_own == 1) ? done_tx : done_rx;
         other_req = (m_own == 1) ? req_rx  : req_tx;
         if (!mine_req || mine_done) m_own = 0;
         else if (m_left == 1) begin
            if (other_req) m_own = 0;
            else m_left = (m_own == 1) ? TQ : RQ;
         end else m_left = m_left - 1;
      end
   end

   task automatic chk(bit ok, string rq, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
      end
   endtask

   // advance one cycle and compare against the model away from the edge
   task automatic cyc(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
         chk((gnt_tx == (m_own == 1)) && (gnt_rx == (m_own == 2)), tag,
             {30'd0, gnt_rx, gnt_tx},
             (m_own == 1) ? 1 : ((m_own == 2) ? 2 : 0));
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin : watchdog
      #(500_000 * 10);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
   end

   initial begin : stim
      int run;
      cyc(2);
      rst = 1'b0;
      chk(gnt_tx == 0 && gnt_rx == 0, "R11", {gnt_rx, gnt_tx}, 0);
      tag = "R1";
      cyc(3);
      chk(gnt_tx == 0 && gnt_rx == 0, "R1", {gnt_rx, gnt_tx}, 0);

      tag = "R2"; req_tx = 1; cyc(1);
      chk(gnt_tx == 1, "R2", gnt_tx, 1);
      tag = "R6"; cyc(10);
      chk(gnt_tx == 1, "R6", gnt_tx, 1);

      tag = "R10"; done_rx = 1; cyc(1); done_rx = 0;
      chk(gnt_tx == 1 && gnt_rx == 0, "R10", {gnt_rx, gnt_tx}, 1);

      tag = "R7"; done_tx = 1; cyc(1); done_tx = 0;
      chk(gnt_tx == 0, "R7", gnt_tx, 0);
      cyc(1);
      chk(gnt_tx == 1, "R2", gnt_tx, 1);
      tag = "R8"; req_tx = 0; cyc(1);
      chk(gnt_tx == 0, "R8", gnt_tx, 0);
      cyc(2);

      tag = "R11"; rst = 1; cyc(1); rst = 0;
      tag = "R3"; req_tx = 1; req_rx = 1; cyc(1);
      chk(gnt_rx == 1 && gnt_tx == 0, "R3", {gnt_rx, gnt_tx}, 2);
      tag = "R5";
      run = 0;
      while (gnt_rx && run < 50) begin run++; cyc(1); end
      chk(run == RQ, "R5", run, RQ);
      chk(gnt_tx == 0 && gnt_rx == 0, "R9", {gnt_rx, gnt_tx}, 0);
      cyc(1);
      chk(gnt_tx == 1, "R4", gnt_tx, 1);
      run = 0;
      while (gnt_tx && run < 50) begin run++; cyc(1); end
      chk(run == TQ, "R5", run, TQ);
      chk(gnt_tx == 0 && gnt_rx == 0, "R9", {gnt_rx, gnt_tx}, 0);
      cyc(1);
      chk(gnt_rx == 1, "R4", gnt_rx, 1);
      // receive finishes early; both still asking: transmit must win the tie
      done_rx = 1; cyc(1); done_rx = 0;
      cyc(1);
      chk(gnt_tx == 1, "R4", gnt_tx, 1);
      req_tx = 0; req_rx = 0; cyc(3);

      tag = "R9";
      for (int k = 0; k < 2000; k++) begin
         int r;
         r = $urandom;
         req_tx  = (r[3:0] != 0);
         req_rx  = (r[7:4] > 3);
         done_tx = (r[12:8] == 0);
         done_rx = (r[17:13] == 0);
         cyc(1);
      end
      req_tx = 0; req_rx = 0; done_tx = 0; done_rx = 0;
      cyc(2);
      chk(gnt_tx == 0 && gnt_rx == 0, "R1", {gnt_rx, gnt_tx}, 0);
      summary();
   end
endmodule